// File: doc/BRIEF.md
# Compare-Driven Event Timer Channel

This block is one timer channel for generating tick or delay interrupts. A 16-bit up-counter advances on a selectable tick: the system clock divided by 2, 8, 32 or 128, or an externally supplied slow (32 kHz class) tick enable. Each qualifying tick compares the counter value against two programmable compare values. The A compare sets a waveform output. The C compare clears that output and ends a counting period.

A mode register chooses what happens on a C match. In periodic mode the counter goes back to zero and keeps counting. In one-shot mode it halts at the compare value until the next software trigger. In free-run mode it ignores the match and wraps at the top of its range. Software drives the channel through a small register port with eight addresses. Three separate command bits turn the counting clock on, turn it off, and restart the counter from zero. Sticky status flags record both compare matches. They can be unmasked onto a single interrupt line, and reading the status clears them.

Top module: `evt_timer_chan`

## Requirements
- R1: After reset the counter, status flags, interrupt mask, interrupt line and waveform output are all zero, and the counter does not advance until the clock is enabled and a trigger has been issued.
- R2: A write to the command address (3) acts on wdata bit 0 (clock on), bit 1 (clock off) and bit 2 (trigger). A trigger zeroes the counter, clears the waveform output and arms counting. Clock-off wins over clock-on written in the same cycle. While the clock is off the counter holds its value.
- R3: With mode bit 3 set and bit 4 clear (periodic), a tick that finds the counter equal to the C compare sets the C flag and returns the counter to zero, so the period is C+1 ticks.
- R4: With mode bit 4 set (one-shot, overriding bit 3), a tick that finds the counter equal to the C compare sets the C flag and halts the counter at that value. Further ticks change nothing until the next trigger.
- R5: With mode bits 3 and 4 clear (free-run), the counter wraps from 0xFFFF to 0. A C match sets the C flag without resetting the counter.
- R6: Status (read at address 6) holds bit 0 = A match and bit 1 = C match. The flags are sticky. A status read returns the flags and clears them, but a match in the same cycle as the read stays set.
- R7: A write to address 4 sets mask bits from wdata[1:0], and a write to address 5 clears them (0xFF clears all). The mask reads back at address 4. The interrupt line is high while any flag is set together with its mask bit, and it drops once the flags are cleared.
- R8: The waveform output goes high on a tick where the counter equals the A compare and low on a tick where it equals the C compare. Clear wins if both match. With A=0 and C=0x8000 in free-run, the output is high for exactly half of each 65536-tick cycle.
- R9: Mode bits [2:0] select the tick: 0 gives clk/2, 1 gives clk/8, 2 gives clk/32, 3 gives clk/128, and 4 gives the slow_tick input. Values 5 to 7 give no ticks.
- R10: Read data appears on rdata one clock after rd_en. Addresses 0, 1, 2 and 7 return the mode, the A compare, the C compare and the counter value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | Slow-rate tick enable, one clock wide |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| irq | output | 1 | Interrupt, any unmasked status flag |
| wave_out | output | 1 | Compare-driven waveform output |

## Verification
A register write takes effect at the clock edge that samples it. Counter, status and waveform changes land on the edge of the qualifying tick. Read data is valid one edge after the read strobe. The interrupt follows the status and mask registers in the same edge that updates them. The bench drives every strobe and slow tick for exactly one cycle on the falling edge and samples on the next falling edge, so each tick is a known, counted edge. Expected counter values, flags and waveform levels come from a closed-form function of the tick count. Prescaler rates are measured as counter differences across a 256-cycle window, which makes the result independent of the divider phase.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

   localparam int SEL_W  = 3;
   localparam int N_SRC  = 2;
   localparam int SRC_A  = 0;
   localparam int SRC_C  = 1;
   localparam int CMD_ON   = 0;
   localparam int CMD_OFF  = 1;
   localparam int CMD_TRIG = 2;

   typedef enum logic [2:0] {
      AD_MODE = 3'd0,
      AD_CMPA = 3'd1,
      AD_CMPC = 3'd2,
      AD_CMD  = 3'd3,
      AD_MSET = 3'd4,
      AD_MCLR = 3'd5,
      AD_STAT = 3'd6,
      AD_CNT  = 3'd7
   } reg_addr_e;

   // bit 4 halt-on-C, bit 3 reload-on-C, bits 2:0 tick select
   typedef struct packed {
      logic             halt;
      logic             reload;
      logic [SEL_W-1:0] sel;
   } mode_t;

endpackage

// File: rtl/evt_timer_prescale.sv
module evt_timer_prescale
   import evt_timer_pkg::*;
#(
   parameter int N_DIV     = 4,
   parameter int LOG_FIRST = 1,
   parameter int LOG_STEP  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slow_tick,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int DIV_W = LOG_FIRST + LOG_STEP * (N_DIV - 1);

   if (LOG_FIRST < 1 || LOG_STEP < 1) begin : g_bad_log
      $error("prescaler tap spacing must be at least one bit");
   end
   if (N_DIV + 1 > (1 << SEL_W)) begin : g_bad_sel
      $error("tick select field too narrow for the divider count");
   end

   logic [DIV_W-1:0] div_q;
   logic [N_DIV-1:0] tap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) div_q <= '0;
      else        div_q <= div_q + DIV_W'(1);
   end

   for (genvar gi = 0; gi < N_DIV; gi++) begin : g_tap
      localparam int LG = LOG_FIRST + LOG_STEP * gi;
      assign tap[gi] = &div_q[LG-1:0];
   end

   always_comb begin
      tick = 1'b0;
      for (int i = 0; i < N_DIV; i++) begin
         if (sel == SEL_W'(i)) tick = tap[i];
      end
      if (sel == SEL_W'(N_DIV)) tick = slow_tick;
   end

   // the fastest tap alternates high and low
   p_div2_alt_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == '0 && $stable(sel) && tick) |=> (sel != '0 || !tick));

endmodule

// File: rtl/evt_timer_core.sv
module evt_timer_core #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             cmd_on,
   input  logic             cmd_off,
   input  logic             cmd_trig,
   input  logic             reload,
   input  logic             halt,
   input  logic [WIDTH-1:0] cmp_a,
   input  logic [WIDTH-1:0] cmp_c,
   output logic [WIDTH-1:0] count,
   output logic             wave,
   output logic             hit_a,
   output logic             hit_c
);
   logic             clk_on_q;
   logic             run_q;
   logic [WIDTH-1:0] cnt_q;
   logic             wave_q;
   logic             adv;

   assign adv   = tick && clk_on_q && run_q && !cmd_trig;
   assign hit_a = adv && (cnt_q == cmp_a);
   assign hit_c = adv && (cnt_q == cmp_c);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_on_q <= 1'b0;
         run_q    <= 1'b0;
         cnt_q    <= '0;
         wave_q   <= 1'b0;
      end else begin
         if (cmd_off)     clk_on_q <= 1'b0;
         else if (cmd_on) clk_on_q <= 1'b1;

         if (cmd_trig)            run_q <= 1'b1;
         else if (hit_c && halt)  run_q <= 1'b0;

         if (cmd_trig)                  cnt_q <= '0;
         else if (hit_c && halt)        cnt_q <= cnt_q;
         else if (hit_c && reload)      cnt_q <= '0;
         else if (adv)                  cnt_q <= cnt_q + WIDTH'(1);

         if (cmd_trig)   wave_q <= 1'b0;
         else if (hit_c) wave_q <= 1'b0;
         else if (hit_a) wave_q <= 1'b1;
      end
   end

   assign count = cnt_q;
   assign wave  = wave_q;

   p_off_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_off |=> !clk_on_q);
   p_trig_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_trig |=> (cnt_q == '0 && !wave_q));
   p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_on_q && !cmd_trig) |=> $stable(cnt_q));
   p_reload_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_c && reload && !halt) |=> (cnt_q == '0));
   p_halt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_c && halt) |=> (!run_q && $stable(cnt_q)));
   p_wave_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hit_c |=> !wave_q);

endmodule

// File: rtl/evt_timer_irq.sv
module evt_timer_irq
   import evt_timer_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] evt,
   input  logic             rd_clr,
   input  logic             mask_set,
   input  logic             mask_clr,
   input  logic [N_SRC-1:0] mask_bits,
   output logic [N_SRC-1:0] stat,
   output logic [N_SRC-1:0] mask,
   output logic             irq
);
   logic [N_SRC-1:0] stat_q;
   logic [N_SRC-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         mask_q <= '0;
      end else begin
         stat_q <= (rd_clr ? '0 : stat_q) | evt;
         if (mask_clr)      mask_q <= mask_q & ~mask_bits;
         else if (mask_set) mask_q <= mask_q | mask_bits;
      end
   end

   assign stat = stat_q;
   assign mask = mask_q;
   assign irq  = |(stat_q & mask_q);

   p_read_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && evt == '0) |=> (stat_q == '0));
   p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_clr |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
   p_irq_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && evt == '0) |=> !irq);
   p_mask_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_clr && mask_bits == '1) |=> !irq);

endmodule

// File: rtl/evt_timer_chan.sv
module evt_timer_chan
   import evt_timer_pkg::*;
#(
   parameter int WIDTH     = 16,
   parameter int N_DIV     = 4,
   parameter int LOG_FIRST = 1,
   parameter int LOG_STEP  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slow_tick,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [2:0]       addr,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] rdata,
   output logic             irq,
   output logic             wave_out
);
   localparam int MODE_W = $bits(mode_t);

   if (WIDTH < 8 || WIDTH < MODE_W) begin : g_bad_width
      $error("data width must hold the mode field and an 8-bit mask write");
   end

   reg_addr_e        ad;
   mode_t            mode_q;
   logic [WIDTH-1:0] cmpa_q, cmpc_q, rdata_q, count;
   logic [N_SRC-1:0] stat, mask, evt;
   logic             tick, cmd_wr, hit_a, hit_c;

   assign ad     = reg_addr_e'(addr);
   assign cmd_wr = wr_en && (ad == AD_CMD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         cmpa_q <= '0;
         cmpc_q <= '0;
      end else if (wr_en) begin
         case (ad)
            AD_MODE: mode_q <= mode_t'(wdata[MODE_W-1:0]);
            AD_CMPA: cmpa_q <= wdata;
            AD_CMPC: cmpc_q <= wdata;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata_q <= '0;
      else if (rd_en) begin
         case (ad)
            AD_MODE: rdata_q <= {{(WIDTH-MODE_W){1'b0}}, mode_q};
            AD_CMPA: rdata_q <= cmpa_q;
            AD_CMPC: rdata_q <= cmpc_q;
            AD_MSET: rdata_q <= {{(WIDTH-N_SRC){1'b0}}, mask};
            AD_STAT: rdata_q <= {{(WIDTH-N_SRC){1'b0}}, stat};
            AD_CNT:  rdata_q <= count;
            default: rdata_q <= '0;
         endcase
      end
   end
   assign rdata = rdata_q;

   evt_timer_prescale #(
      .N_DIV(N_DIV), .LOG_FIRST(LOG_FIRST), .LOG_STEP(LOG_STEP)
   ) u_pre (
      .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
      .sel(mode_q.sel), .tick(tick)
   );

   evt_timer_core #(.WIDTH(WIDTH)) u_core (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .cmd_on(cmd_wr && wdata[CMD_ON]),
      .cmd_off(cmd_wr && wdata[CMD_OFF]),
      .cmd_trig(cmd_wr && wdata[CMD_TRIG]),
      .reload(mode_q.reload), .halt(mode_q.halt),
      .cmp_a(cmpa_q), .cmp_c(cmpc_q),
      .count(count), .wave(wave_out), .hit_a(hit_a), .hit_c(hit_c)
   );

   always_comb begin
      evt        = '0;
      evt[SRC_A] = hit_a;
      evt[SRC_C] = hit_c;
   end

   evt_timer_irq u_irq (
      .clk(clk), .rst_n(rst_n), .evt(evt),
      .rd_clr(rd_en && ad == AD_STAT),
      .mask_set(wr_en && ad == AD_MSET),
      .mask_clr(wr_en && ad == AD_MCLR),
      .mask_bits(wdata[N_SRC-1:0]),
      .stat(stat), .mask(mask), .irq(irq)
   );

   p_rd_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));

endmodule

// File: tb/evt_timer_chan_tb_top.sv
module evt_timer_chan_tb_top;
   localparam int W = 16;

   logic         clk = 1'b0, rst_n = 1'b0, slow_tick = 1'b0;
   logic         wr_en = 1'b0, rd_en = 1'b0;
   logic [2:0]   addr = '0;
   logic [W-1:0] wdata = '0;
   logic [W-1:0] rdata;
   logic         irq, wave_out;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   evt_timer_chan dut_i (
      .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wr_en(wr_en),
      .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
      .irq(irq), .wave_out(wave_out)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      d = rdata; rd_en = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         slow_tick = 1'b1;
         @(negedge clk);
         slow_tick = 1'b0;
      end
   endtask

   // m: 0 periodic, 1 one-shot, 2 free-run; returns {wave, C, A, count}
   function automatic logic [18:0] model(input int m, input int ra, input int rc, input int k);
      int n, c, v;
      logic wv;
      n = (m == 1 && k > rc + 1) ? rc + 1 : k;
      if (m == 0)      c = k % (rc + 1);
      else if (m == 1) c = (k < rc) ? k : rc;
      else             c = k;
      v  = (m == 0) ? (k - 1) % (rc + 1) : n - 1;
      wv = (n > 0) && (ra <= v) && (v < rc);
      return {wv, logic'(n > rc), logic'(n > ra), c[15:0]};
   endfunction

   task automatic run_case(input int m, input int ra, input int rc, input int k);
      logic [W-1:0] d;
      logic [18:0]  e;
      string        tag;
      tag = (m == 0) ? "R3" : (m == 1) ? "R4" : "R5";
      wr(3'd0, (m == 0) ? 16'h000C : (m == 1) ? 16'h0014 : 16'h0004);
      wr(3'd1, W'(ra));
      wr(3'd2, W'(rc));
      rd(3'd6, d);
      wr(3'd3, 16'h0005);
      ticks(k);
      e = model(m, ra, rc, k);
      check({"R8 wave ", tag}, 32'(wave_out), 32'(e[18]));
      rd(3'd6, d);
      check({"R6 status ", tag}, 32'(d), 32'(e[17:16]));
      rd(3'd7, d);
      check({tag, " count"}, 32'(d), 32'(e[15:0]));
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [W-1:0] d, c0, c1;
      int hi;
      int m, rc, ra, k;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 irq", 32'(irq), 0);
      check("R1 wave", 32'(wave_out), 0);
      rd(3'd6, d); check("R1 status", 32'(d), 0);
      rd(3'd4, d); check("R1 mask", 32'(d), 0);
      wr(3'd0, 16'h000C); wr(3'd2, 16'h0010);
      ticks(3);
      rd(3'd7, d); check("R1 no count before trigger", 32'(d), 0);

      // R10 readback
      wr(3'd1, 16'h0003);
      rd(3'd0, d); check("R10 mode readback", 32'(d), 32'h0C);
      rd(3'd1, d); check("R10 cmpa readback", 32'(d), 32'h03);
      rd(3'd2, d); check("R10 cmpc readback", 32'(d), 32'h10);

      // directed periodic / one-shot / free-run cases
      run_case(0, 2, 5, 5);
      run_case(0, 2, 5, 6);
      run_case(0, 2, 5, 13);
      run_case(1, 2, 5, 6);
      run_case(1, 1, 4, 20);
      run_case(0, 4, 4, 12);
      run_case(2, 3, 6, 9);

      // R2 clock-off priority and trigger without clock
      wr(3'd0, 16'h000C); wr(3'd2, 16'd100);
      wr(3'd3, 16'h0005); ticks(3);
      wr(3'd3, 16'h0003); ticks(4);
      rd(3'd7, d); check("R2 off wins, count held", 32'(d), 3);
      wr(3'd3, 16'h0001); ticks(2);
      rd(3'd7, d); check("R2 count resumes", 32'(d), 5);
      wr(3'd3, 16'h0006); ticks(3);
      rd(3'd7, d); check("R2 trigger without clock", 32'(d), 0);
      wr(3'd3, 16'h0001); ticks(2);
      rd(3'd7, d); check("R2 count after clock on", 32'(d), 2);

      // R7 mask and interrupt
      wr(3'd1, 16'h0003); wr(3'd2, 16'h0003);
      rd(3'd6, d);
      wr(3'd3, 16'h0005); ticks(4);
      check("R7 masked irq low", 32'(irq), 0);
      wr(3'd4, 16'h0002); check("R7 C unmasked irq", 32'(irq), 1);
      wr(3'd5, 16'h00FF); check("R7 all masked", 32'(irq), 0);
      wr(3'd4, 16'h0001); check("R7 A unmasked irq", 32'(irq), 1);
      rd(3'd4, d); check("R7 mask readback", 32'(d), 1);
      rd(3'd6, d); check("R6 both flags", 32'(d), 3);
      check("R7 irq drops after read", 32'(irq), 0);
      wr(3'd5, 16'h00FF);

      // R6 match coinciding with status read
      wr(3'd1, 16'h0000); wr(3'd2, 16'h0002);
      wr(3'd3, 16'h0005); ticks(2);
      rd(3'd6, d); check("R6 A flag", 32'(d), 1);
      addr = 3'd6; rd_en = 1'b1; slow_tick = 1'b1;
      @(negedge clk);
      d = rdata; rd_en = 1'b0; slow_tick = 1'b0;
      check("R6 read during match", 32'(d), 0);
      rd(3'd6, d); check("R6 match survives read", 32'(d), 2);
      rd(3'd7, d); check("R3 reload to zero", 32'(d), 0);

      // R9 prescaler rates
      for (int s = 0; s < 4; s++) begin
         wr(3'd0, W'(8 + s)); wr(3'd2, 16'hFFFF); wr(3'd3, 16'h0005);
         rd(3'd7, c0);
         repeat (255) @(negedge clk);
         rd(3'd7, c1);
         check("R9 divider rate", 32'(c1 - c0), 32'(256 >> (1 + 2 * s)));
      end
      wr(3'd0, 16'h000D); wr(3'd3, 16'h0005);
      rd(3'd7, c0); repeat (255) @(negedge clk); rd(3'd7, c1);
      check("R9 unused select", 32'(c1 - c0), 0);

      // random cases
      for (int it = 0; it < 40; it++) begin
         m  = int'($urandom_range(2, 0));
         rc = int'($urandom_range(20, 1));
         ra = int'($urandom_range(rc, 0));
         k  = int'($urandom_range(50, 0));
         run_case(m, ra, rc, k);
      end

      // R8 / R5 half-duty free-run over one full wrap
      wr(3'd0, 16'h0004); wr(3'd1, 16'h0000); wr(3'd2, 16'h8000);
      rd(3'd6, d);
      addr = 3'd3; wdata = 16'h0005; wr_en = 1'b1; slow_tick = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      hi = 0;
      for (int i = 0; i < 65536; i++) begin
         @(negedge clk);
         if (wave_out) hi++;
      end
      slow_tick = 1'b0;
      check("R8 half duty", 32'(hi), 32768);
      rd(3'd6, d); check("R5 flags in free-run", 32'(d), 3);
      rd(3'd7, d); check("R5 wrap to zero", 32'(d), 0);

      finish_run();
   end

endmodule